// File: doc/BRIEF.md
# SPI Serial-Clock Prescaler

This block produces the timing for the serial clock of an SPI shift engine. It takes a prescale field that software has already computed and a run input. From these it produces three things. The first is a phase level that says whether the serial clock is in its high or low half. The second is a pair of one-cycle strobes: one marks the leading edge and one marks the trailing edge. The third is a combined edge strobe. A shift engine uses these strobes as clock enables, and it decides from its clock mode which edge samples and which edge shifts.

A parameter selects between two decodings of the prescale field. The compact decoding gives even divisors from 4 to 30 from a five-bit code. The wide decoding multiplies a four-bit linear factor by a power of two taken from a three-bit exponent, which reaches divisors up to 1920. The block decodes the field, splits the divisor into a low half and a high half, and runs a half-period counter. The counter is cleared while run is low. The decoded setting is captured only while run is low, so the clock stays steady for the whole of a transfer. Choosing a field value for a wanted bit rate is outside this block.

The interface carries no data stream. All pins are plain level or pulse controls, so no valid/ready handshake applies.

Top module: `spi_sck_prescaler`

## Requirements
- R1: Compact decoding: with v = prescale_field[4:0] and v at 0x12 or above, the divisor is 2*(v-16). This gives the even values 4 to 30. Bits 7:5 have no effect.
- R2: Compact decoding: any v below 0x12 runs at divisor 4.
- R3: Wide decoding: the divisor is lin * 2^exp. The linear factor lin is prescale_field[3:0]. The exponent exp is the three-bit value {prescale_field[7:6], prescale_field[4]}, so field bit 4 is the least significant exponent bit. Bit 5 has no effect.
- R4: Wide decoding: a linear factor of 0 is treated as 1.
- R5: Wide decoding: a computed divisor of 1 runs at divisor 2.
- R6: For a divisor N, the low half lasts floor(N/2) clocks and the high half lasts ceil(N/2) clocks. sck_phase is 0 in the low half and 1 in the high half. lead_tick marks the last clock of the low half. trail_tick marks the last clock of the high half.
- R7: While run is low, the half counter is cleared, sck_phase is 0 from the next clock, and no strobe is asserted. When run has been high for t clocks (t = 0 in the first such clock), lead_tick is asserted when t mod N = floor(N/2)-1 and trail_tick is asserted when t mod N = N-1.
- R8: The divisor is captured on every clock where run is low. Changes to prescale_field while run is high are ignored until run goes low again.
- R9: sck_edge equals lead_tick OR trail_tick. lead_tick and trail_tick are never asserted in the same clock.
- R10: While reset is held, and afterwards while run is low, all strobes and sck_phase are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prescale_field | input | 8 | Prescale code, decoded according to the variant parameter |
| run | input | 1 | High while the serial clock is to run; low clears the counter and captures the setting |
| sck_phase | output | 1 | Current serial-clock half: 0 low, 1 high |
| lead_tick | output | 1 | Strobe for the clock that ends the low half |
| trail_tick | output | 1 | Strobe for the clock that ends the high half |
| sck_edge | output | 1 | Strobe for either edge |

## Verification
All 256 field codes are applied to a wide instance and a compact instance at the same time. For each code, the strobes and the phase are compared, clock by clock, against a period computed in arithmetic. Even divisors check the symmetric halves. Odd divisors check that the high half is the longer one. The zero-factor and clamped codes check R2, R4 and R5. The codes that differ only in bits the decoder ignores check that those bits have no effect. A separate run changes the field in the middle of a transfer and checks that the old period continues and that the new code takes effect only after run drops.

// File: rtl/spi_presc_pkg.sv
package spi_presc_pkg;

  typedef enum logic {
    PRESC_COMPACT  = 1'b0,
    PRESC_WIDE     = 1'b1
  } presc_variant_e;

  // Field layout (fixed by the decode rules)
  localparam int PRESC_FIELD_W = 8;
  localparam int PRESC_LIN_W   = 4;
  localparam int PRESC_EXP_W   = 3;
  localparam int PRESC_CODE_W  = 5;

  // Largest divisor needs LIN_W bits shifted by up to 2^EXP_W-1 places
  localparam int PRESC_DIV_W   = PRESC_LIN_W + (1 << PRESC_EXP_W) - 1;

  // Compact decoding limits
  localparam int PRESC_CODE_BASE = 16;
  localparam int PRESC_CODE_MIN  = 18;
  localparam int PRESC_MIN_DIV   = 2;

endpackage

// File: rtl/presc_decode.sv
module presc_decode
  import spi_presc_pkg::*;
#(
  parameter presc_variant_e VARIANT = PRESC_WIDE,
  parameter int FIELD_W = PRESC_FIELD_W,
  parameter int DIV_W   = PRESC_DIV_W
) (
  input  logic [FIELD_W-1:0] field,
  output logic [DIV_W-1:0]   divisor
);

  generate
    if (VARIANT == PRESC_WIDE) begin : g_wide
      logic [PRESC_LIN_W-1:0] lin;
      logic [PRESC_LIN_W-1:0] lin_eff;
      logic [PRESC_EXP_W-1:0] expo;

      always_comb begin
        lin     = field[PRESC_LIN_W-1:0];
        // R4: a zero factor behaves as one so the divider never stalls
        lin_eff = (lin == '0) ? PRESC_LIN_W'(1) : lin;
        // R3: exponent bit 0 sits at bit 4, bits 2:1 at bits 7:6
        expo    = {field[7:6], field[4]};
        divisor = DIV_W'(lin_eff) << expo;
      end
    end else begin : g_compact
      logic [PRESC_CODE_W-1:0] code;

      always_comb begin
        code = field[PRESC_CODE_W-1:0];
        if (code < PRESC_CODE_W'(PRESC_CODE_MIN)) begin
          divisor = DIV_W'(4);                         // R2 clamp
        end else begin
          divisor = DIV_W'(2 * (int'(code) - PRESC_CODE_BASE)); // R1
        end
      end
    end
  endgenerate

endmodule

// File: rtl/presc_split.sv
module presc_split
  import spi_presc_pkg::*;
#(
  parameter int DIV_W = PRESC_DIV_W
) (
  input  logic [DIV_W-1:0] divisor,
  output logic [DIV_W-1:0] lo_len,
  output logic [DIV_W-1:0] hi_len
);

  logic [DIV_W-1:0] div_eff;
  logic [DIV_W:0]   div_up;

  always_comb begin
    // R5: divisor 1 cannot be split into two halves; run it at 2
    div_eff = (divisor < DIV_W'(PRESC_MIN_DIV)) ? DIV_W'(PRESC_MIN_DIV) : divisor;
    div_up  = {1'b0, div_eff} + (DIV_W+1)'(1);
    lo_len  = div_eff >> 1;                 // floor(N/2)
    hi_len  = div_up[DIV_W:1];              // ceil(N/2)
  end

endmodule

// File: rtl/presc_phase_gen.sv
module presc_phase_gen
  import spi_presc_pkg::*;
#(
  parameter int DIV_W = PRESC_DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] lo_len,
  input  logic [DIV_W-1:0] hi_len,
  output logic             phase,
  output logic             lead,
  output logic             trail
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] cur_len;
  logic             last;

  always_comb begin
    cur_len = phase ? hi_len : lo_len;
    last    = run && (cnt == cur_len - DIV_W'(1));
    lead    = last && !phase;
    trail   = last && phase;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (!run) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (last) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt   <= cnt + DIV_W'(1);
    end
  end

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!lead && !trail));

  a_r7_idle_phase_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !phase);

  a_r6_lead_enters_high: assert property (@(posedge clk) disable iff (!rst_n)
    lead |=> phase);

  a_r6_trail_enters_low: assert property (@(posedge clk) disable iff (!rst_n)
    trail |=> !phase);

  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < cur_len);

  a_r6_phase_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !last) |=> $stable(phase));

endmodule

// File: rtl/spi_sck_prescaler.sv
module spi_sck_prescaler
  import spi_presc_pkg::*;
#(
  parameter presc_variant_e VARIANT = PRESC_WIDE,
  parameter int FIELD_W = PRESC_FIELD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FIELD_W-1:0] prescale_field,
  input  logic               run,
  output logic               sck_phase,
  output logic               lead_tick,
  output logic               trail_tick,
  output logic               sck_edge
);

  localparam int DIV_W = PRESC_DIV_W;
  localparam int MAX_WIDE_DIV = ((1 << PRESC_LIN_W) - 1) << ((1 << PRESC_EXP_W) - 1);

  logic [DIV_W-1:0] divisor;
  logic [DIV_W-1:0] lo_d, hi_d;
  logic [DIV_W-1:0] lo_q, hi_q;

  presc_decode #(
    .VARIANT (VARIANT),
    .FIELD_W (FIELD_W),
    .DIV_W   (DIV_W)
  ) u_decode (
    .field   (prescale_field),
    .divisor (divisor)
  );

  presc_split #(
    .DIV_W   (DIV_W)
  ) u_split (
    .divisor (divisor),
    .lo_len  (lo_d),
    .hi_len  (hi_d)
  );

  // R8: setting captured only while the clock is stopped
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= DIV_W'(2);
      hi_q <= DIV_W'(2);
    end else if (!run) begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  presc_phase_gen #(
    .DIV_W  (DIV_W)
  ) u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .lo_len (lo_q),
    .hi_len (hi_q),
    .phase  (sck_phase),
    .lead   (lead_tick),
    .trail  (trail_tick)
  );

  assign sck_edge = lead_tick | trail_tick;

  generate
    if (VARIANT == PRESC_WIDE) begin : g_chk_wide
      a_r3_div_range: assert property (@(posedge clk) disable iff (!rst_n)
        (divisor != '0) && (divisor <= DIV_W'(MAX_WIDE_DIV)));
    end else begin : g_chk_compact
      a_r1_div_range: assert property (@(posedge clk) disable iff (!rst_n)
        !divisor[0] && (divisor >= DIV_W'(4)) && (divisor <= DIV_W'(30)));
    end
  endgenerate

  a_r8_setting_held: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> ($stable(lo_q) && $stable(hi_q)));

  a_r6_halves_balanced: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_q != '0) && (hi_q >= lo_q) && ((hi_q - lo_q) <= DIV_W'(1)));

  a_r9_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead_tick && trail_tick));

  a_r10_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!sck_phase && !sck_edge));

endmodule

// File: tb/tb_spi_sck_prescaler.sv
module tb_spi_sck_prescaler;
  import spi_presc_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] field = 8'h00;
  logic       run = 1'b0;

  logic w_phase, w_lead, w_trail, w_edge;
  logic c_phase, c_lead, c_trail, c_edge;

  int vectors = 0;
  int fails = 0;
  int cur_f = 0;
  int cur_t = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_sck_prescaler #(.VARIANT(PRESC_WIDE)) dut (
    .clk(clk), .rst_n(rst_n), .prescale_field(field), .run(run),
    .sck_phase(w_phase), .lead_tick(w_lead), .trail_tick(w_trail), .sck_edge(w_edge)
  );

  spi_sck_prescaler #(.VARIANT(PRESC_COMPACT)) dut_cmp (
    .clk(clk), .rst_n(rst_n), .prescale_field(field), .run(run),
    .sck_phase(c_phase), .lead_tick(c_lead), .trail_tick(c_trail), .sck_edge(c_edge)
  );

  function automatic int wide_div(input int f);
    int lin, e, n;
    lin = f & 15;
    if (lin == 0) lin = 1;                                      // R4
    e = (((f >> 6) & 3) << 1) | ((f >> 4) & 1);                 // R3
    n = lin << e;
    if (n < 2) n = 2;                                           // R5
    return n;
  endfunction

  function automatic int compact_div(input int f);
    int v;
    v = f & 31;
    return (v < 18) ? 4 : 2 * (v - 16);                         // R1, R2
  endfunction

  task automatic chk(input string rq, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s field=%02h t=%0d got %0b expected %0b", rq, cur_f, cur_t, act, exp);
    end
  endtask

  task automatic chk_timing(input string rq, input int n, input int t,
                            input logic ph, input logic ld, input logic tr, input logic ed);
    int m, lo;
    logic e_ld, e_tr;
    m  = t % n;
    lo = n / 2;
    e_ld = (m == lo - 1);
    e_tr = (m == n - 1);
    chk(rq, ld, e_ld);
    chk(rq, tr, e_tr);
    chk("R6", ph, (m >= lo));
    chk("R9", ed, e_ld | e_tr);
  endtask

  task automatic chk_idle(input string rq);
    chk(rq, w_phase, 1'b0); chk(rq, w_edge, 1'b0);
    chk(rq, c_phase, 1'b0); chk(rq, c_edge, 1'b0);
  endtask

  function automatic string wide_tag(input int f);
    int lin, e;
    lin = f & 15;
    e = (((f >> 6) & 3) << 1) | ((f >> 4) & 1);
    if (lin <= 1 && e == 0) return "R5";
    if (lin == 0) return "R4";
    return "R3";
  endfunction

  // run high for len cycles, checking both instances against given divisors
  task automatic run_window(input int len, input int nw, input int nc,
                            input int change_at, input logic [7:0] new_f);
    for (int t = 0; t < len; t++) begin
      @(negedge clk);
      run = 1'b1;
      if (t == change_at) field = new_f;                        // R8 stimulus
      cur_t = t;
      #1;
      chk_timing(wide_tag(cur_f), nw, t, w_phase, w_lead, w_trail, w_edge);
      chk_timing(((cur_f & 31) < 18) ? "R2" : "R1", nc, t, c_phase, c_lead, c_trail, c_edge);
    end
  endtask

  initial begin : watchdog
    for (int i = 0; i < WATCHDOG_CYCLES; i++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    // R10: reset state
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      cur_t = -1;
      chk_idle("R10");
    end
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk_idle("R10");

    // Full sweep of field codes
    for (int f = 0; f < 256; f++) begin
      int nw, nc, len;
      cur_f = f;
      nw = wide_div(f);
      nc = compact_div(f);
      @(negedge clk); run = 1'b0; field = 8'(f);
      @(negedge clk); #1;
      cur_t = -1;
      chk_idle("R7");
      len = ((nw > nc) ? nw : nc) + nw / 2 + 2;
      run_window(len, nw, nc, -1, 8'h00);
    end

    // R8: change during run is ignored, then applied after run drops
    @(negedge clk); run = 1'b0; field = 8'h13;
    @(negedge clk);
    cur_f = 8'h13;
    run_window(40, 6, 6, 2, 8'h5F);
    @(negedge clk); run = 1'b0;
    @(negedge clk); #1;
    cur_t = -1;
    chk_idle("R7");
    cur_f = 8'h5F;
    run_window(200, wide_div(8'h5F), compact_div(8'h5F), -1, 8'h00);
    chk("R8", 1'(wide_div(8'h5F) == 120), 1'b1);

    @(negedge clk); run = 1'b0;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule